// File: doc/BRIEF.md
# Upper Context Save Engine

This block pushes the sixteen-word upper register context of a processor into a free-list of context save areas in memory. A request carries the current previous-context-info word, the free-list head pointer, the list limit, the current priority number and the interrupt enable. It also carries the fifteen remaining context words. The engine turns the head pointer into an area base address. It reads the link word stored at that base, then writes the sixteen words into the area one after another.

When the last write is accepted, the engine commits a new previous-context-info word and a new head pointer on its outputs and pulses `done`. A head pointer of zero means the list is empty. In that case the engine pulses `empty`, touches no memory and commits nothing. When the head pointer that was consumed equals the limit, `depleted` is raised together with `done`. Raising a trap for either condition is left to the surrounding logic.

The request side is valid/ready. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is high only while the engine is idle. The memory side is also valid/ready. The engine holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` unchanged until the edge where `mem_ready` is high, so the memory may stall any transfer for as long as it needs. Read data returns on a later edge marked by `mem_rvalid`, and that return is never back-pressured.

Top module: `upper_ctx_saver`

## Requirements
- R1: `req_ready` is high exactly when the engine is idle. From acceptance until the cycle in which `done` or `empty` shows, `req_ready` stays low.
- R2: A request whose head pointer is 0 makes `empty` high for one cycle, in the cycle right after the accepting edge. It issues no memory transfer, raises no `done`, and leaves `pcxi_o` and `head_o` unchanged.
- R3: The area base address places head bits [19:16] at address bits [31:28] and head bits [15:0] at address bits [21:6]. All other base bits are zero. Word k of the area sits at base + 4·k.
- R4: The first memory transfer of a save is a single read (`mem_we` = 0) at the base address. The data on `mem_rdata` at the edge where `mem_rvalid` is high is taken as the link.
- R5: After the link is taken, exactly sixteen writes follow, to words 0..15 in order. Word 0 is the request's previous-context-info word. Words 1..15 are `req_ctx` slices 0..14, where slice j is bits [32·j+31 : 32·j], in the order status, A10, A11, D8..D11, A12..A15, D12..D15. Each transfer holds its address, data and direction stable while `mem_ready` is low.
- R6: The committed `pcxi_o` takes the priority number in bits [31:24] and the interrupt enable in bit 23. Bit 22 (upper-context flag) is set to 1. Bits [21:20] keep their request values, and bits [19:0] take the old head bits [19:0].
- R7: The committed `head_o` keeps the old head bits [31:20] and takes the link bits [19:0].
- R8: `done` is high for exactly one cycle, the cycle right after the edge that accepts the sixteenth write. `pcxi_o` and `head_o` change in that same cycle and hold until the next commit.
- R9: `depleted` is high together with `done` when the old head pointer equals the request limit over all 32 bits. Otherwise it is low.
- R10: After reset `req_ready` is 1, and `mem_valid`, `done`, `empty`, `depleted`, `pcxi_o` and `head_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Save request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_pcxi | input | 32 | Current previous-context-info word |
| req_head | input | 32 | Current free-list head pointer |
| req_limit | input | 32 | Free-list limit pointer |
| req_ccpn | input | 8 | Current priority number |
| req_ie | input | 1 | Current interrupt enable |
| req_ctx | input | 480 | Context words 1..15, word k in slice k-1 |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts the transfer |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle pulse on commit |
| depleted | output | 1 | Consumed head equalled the limit (with done) |
| empty | output | 1 | One-cycle pulse: head pointer was zero |
| pcxi_o | output | 32 | Committed previous-context-info word |
| head_o | output | 32 | Committed free-list head pointer |

## Verification
The bench stamps every handshake with the number of the rising edge it happened on: request acceptance, each memory transfer, and the read return. It samples the outputs on falling edges. `empty` must show in the cycle that carries the acceptance edge's number, and `done`, `depleted` and the new `pcxi_o`/`head_o` must show in the cycle that carries the sixteenth write's number. One cycle later `done` must be low again. The memory model stalls `mem_ready` in a pseudo-random pattern and delays read data by 0 to 3 cycles. This shows that the order and timing of the results follow the handshakes and not fixed cycle counts.

// File: rtl/csave_pkg.sv
package csave_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned AW        = 32;
  localparam int unsigned CTX_WORDS = 16;
  localparam int unsigned PRIO_W    = 8;
  localparam int unsigned LINK_W    = 20;
  localparam int unsigned SEG_W     = 4;
  localparam int unsigned OFF_W     = 16;
  localparam int unsigned PRIO_LSB  = 24;
  localparam int unsigned PIE_BIT   = 23;
  localparam int unsigned UL_BIT    = 22;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WRITE = 2'd3
  } save_state_e;
endpackage

// File: rtl/csa_addr_gen.sv
module csa_addr_gen #(
  parameter int unsigned AW     = 32,
  parameter int unsigned SEG_W  = 4,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [SEG_W+OFF_W-1:0] head_ptr,
  input  logic [IDX_W-1:0]       word_idx,
  output logic [AW-1:0]          word_addr
);
  localparam int unsigned OFF_LSB = IDX_W + 2;

  always_comb begin
    word_addr = '0;
    word_addr[AW-1 -: SEG_W]     = head_ptr[OFF_W +: SEG_W];
    word_addr[OFF_LSB +: OFF_W]  = head_ptr[OFF_W-1:0];
    word_addr[2 +: IDX_W]        = word_idx;
  end
endmodule

// File: rtl/ctx_word_sel.sv
module ctx_word_sel #(
  parameter int unsigned DW        = 32,
  parameter int unsigned CTX_WORDS = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [DW-1:0]               first_word,
  input  logic [(CTX_WORDS-1)*DW-1:0] rest_words,
  input  logic [IDX_W-1:0]            sel,
  output logic [DW-1:0]               word_out
);
  logic [DW-1:0] slots [CTX_WORDS];

  assign slots[0] = first_word;

  for (genvar g = 1; g < CTX_WORDS; g++) begin : g_slot
    assign slots[g] = rest_words[(g-1)*DW +: DW];
  end

  assign word_out = slots[sel];
endmodule

// File: rtl/cxi_update.sv
module cxi_update #(
  parameter int unsigned DW       = 32,
  parameter int unsigned PRIO_W   = 8,
  parameter int unsigned LINK_W   = 20,
  parameter int unsigned PRIO_LSB = 24,
  parameter int unsigned PIE_BIT  = 23,
  parameter int unsigned UL_BIT   = 22
) (
  input  logic [DW-1:0]     old_pcxi,
  input  logic [DW-1:0]     old_head,
  input  logic [DW-1:0]     limit,
  input  logic [LINK_W-1:0] link,
  input  logic [PRIO_W-1:0] prio,
  input  logic              int_en,
  output logic [DW-1:0]     new_pcxi,
  output logic [DW-1:0]     new_head,
  output logic              at_limit
);
  always_comb begin
    new_pcxi                       = old_pcxi;
    new_pcxi[PRIO_LSB +: PRIO_W]   = prio;
    new_pcxi[PIE_BIT]              = int_en;
    new_pcxi[UL_BIT]               = 1'b1;
    new_pcxi[LINK_W-1:0]           = old_head[LINK_W-1:0];

    new_head                       = old_head;
    new_head[LINK_W-1:0]           = link;

    at_limit                       = (old_head == limit);
  end
endmodule

// File: rtl/upper_ctx_saver.sv
module upper_ctx_saver
  import csave_pkg::*;
#(
  parameter int unsigned DATA_W  = DW,
  parameter int unsigned ADDR_W  = AW,
  parameter int unsigned N_WORDS = CTX_WORDS
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [DATA_W-1:0]               req_pcxi,
  input  logic [DATA_W-1:0]               req_head,
  input  logic [DATA_W-1:0]               req_limit,
  input  logic [PRIO_W-1:0]               req_ccpn,
  input  logic                            req_ie,
  input  logic [(N_WORDS-1)*DATA_W-1:0]   req_ctx,
  output logic                            mem_valid,
  input  logic                            mem_ready,
  output logic                            mem_we,
  output logic [ADDR_W-1:0]               mem_addr,
  output logic [DATA_W-1:0]               mem_wdata,
  input  logic                            mem_rvalid,
  input  logic [DATA_W-1:0]               mem_rdata,
  output logic                            done,
  output logic                            depleted,
  output logic                            empty,
  output logic [DATA_W-1:0]               pcxi_o,
  output logic [DATA_W-1:0]               head_o
);
  localparam int unsigned IDX_W  = $clog2(N_WORDS);
  localparam int unsigned HP_W   = SEG_W + OFF_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  save_state_e state_q;

  logic [DATA_W-1:0]             pcxi_q, head_q, limit_q;
  logic [PRIO_W-1:0]             prio_q;
  logic                          ie_q;
  logic [(N_WORDS-1)*DATA_W-1:0] ctx_q;
  logic [LINK_W-1:0]             link_q;
  logic [IDX_W-1:0]              idx_q;

  logic                          done_q, depl_q, empty_q;
  logic [DATA_W-1:0]             pcxi_out_q, head_out_q;

  logic [ADDR_W-1:0]             addr_w;
  logic [DATA_W-1:0]             word_w;
  logic [DATA_W-1:0]             nxt_pcxi, nxt_head;
  logic                          hit_limit;
  logic [IDX_W-1:0]              addr_idx;

  wire unused_rdata_hi = ^mem_rdata[DATA_W-1:LINK_W];

  wire accept   = req_valid && req_ready;
  wire xfer     = mem_valid && mem_ready;
  wire last_wr  = (state_q == ST_WRITE) && xfer && (idx_q == LAST_IDX);

  // the read targets word 0; writes walk the index
  assign addr_idx = (state_q == ST_WRITE) ? idx_q : '0;

  csa_addr_gen #(
    .AW    (ADDR_W),
    .SEG_W (SEG_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_addr (
    .head_ptr  (head_q[HP_W-1:0]),
    .word_idx  (addr_idx),
    .word_addr (addr_w)
  );

  ctx_word_sel #(
    .DW        (DATA_W),
    .CTX_WORDS (N_WORDS),
    .IDX_W     (IDX_W)
  ) u_sel (
    .first_word (pcxi_q),
    .rest_words (ctx_q),
    .sel        (idx_q),
    .word_out   (word_w)
  );

  cxi_update #(
    .DW       (DATA_W),
    .PRIO_W   (PRIO_W),
    .LINK_W   (LINK_W),
    .PRIO_LSB (PRIO_LSB),
    .PIE_BIT  (PIE_BIT),
    .UL_BIT   (UL_BIT)
  ) u_upd (
    .old_pcxi (pcxi_q),
    .old_head (head_q),
    .limit    (limit_q),
    .link     (link_q),
    .prio     (prio_q),
    .int_en   (ie_q),
    .new_pcxi (nxt_pcxi),
    .new_head (nxt_head),
    .at_limit (hit_limit)
  );

  // memory port is a pure function of the state registers
  always_comb begin
    req_ready = (state_q == ST_IDLE);
    mem_valid = (state_q == ST_READ) || (state_q == ST_WRITE);
    mem_we    = (state_q == ST_WRITE);
    mem_addr  = mem_valid ? addr_w : '0;
    mem_wdata = (state_q == ST_WRITE) ? word_w : '0;
  end

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcxi_q  <= '0;
      head_q  <= '0;
      limit_q <= '0;
      prio_q  <= '0;
      ie_q    <= 1'b0;
      ctx_q   <= '0;
    end else if (accept) begin
      pcxi_q  <= req_pcxi;
      head_q  <= req_head;
      limit_q <= req_limit;
      prio_q  <= req_ccpn;
      ie_q    <= req_ie;
      ctx_q   <= req_ctx;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      link_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && (req_head != '0)) begin
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (xfer) begin
            state_q <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            link_q  <= mem_rdata[LINK_W-1:0];
            idx_q   <= '0;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (xfer) begin
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IDLE;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // result commit and condition pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      depl_q     <= 1'b0;
      empty_q    <= 1'b0;
      pcxi_out_q <= '0;
      head_out_q <= '0;
    end else begin
      done_q  <= last_wr;
      depl_q  <= last_wr && hit_limit;
      empty_q <= accept && (req_head == '0);
      if (last_wr) begin
        pcxi_out_q <= nxt_pcxi;
        head_out_q <= nxt_head;
      end
    end
  end

  assign done     = done_q;
  assign depleted = depl_q;
  assign empty    = empty_q;
  assign pcxi_o   = pcxi_out_q;
  assign head_o   = head_out_q;
endmodule

// File: rtl/upper_ctx_saver_chk.sv
module upper_ctx_saver_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              done,
  input logic              depleted,
  input logic              empty,
  input logic [DATA_W-1:0] pcxi_o
);
  // R1: no memory activity while a request can be taken
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  // R2: empty list causes no memory transfer and no commit
  p_empty_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!mem_valid && !done));

  // R3: zero gap between segment and offset, word aligned
  p_addr_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[27:22] == 6'd0 && mem_addr[1:0] == 2'd0));

  // R5: a stalled transfer holds still
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  // R6: committed word carries the upper-context flag
  p_ul_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pcxi_o[22]);

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: depletion only reported with a commit
  p_depl_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depleted |-> done);
endmodule

bind upper_ctx_saver upper_ctx_saver_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .done      (done),
  .depleted  (depleted),
  .empty     (empty),
  .pcxi_o    (pcxi_o)
);

// File: tb/tb_upper_ctx_saver.sv
module tb_upper_ctx_saver;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_pcxi = '0, req_head = '0, req_limit = '0;
  logic [7:0]   req_ccpn = '0;
  logic         req_ie = 1'b0;
  logic [479:0] req_ctx = '0;
  logic         mem_valid, mem_we;
  logic         mem_ready = 1'b1;
  logic [31:0]  mem_addr, mem_wdata;
  logic         mem_rvalid = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic         done, depleted, empty;
  logic [31:0]  pcxi_o, head_o;

  upper_ctx_saver dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_pcxi(req_pcxi), .req_head(req_head), .req_limit(req_limit),
    .req_ccpn(req_ccpn), .req_ie(req_ie), .req_ctx(req_ctx),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .depleted(depleted), .empty(empty),
    .pcxi_o(pcxi_o), .head_o(head_o)
  );

  always #2 clk = ~clk;  // 4 ns period

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  // memory model state
  int          n_rd, n_wr, rd_before_wr, acc_cyc, last_wr_cyc;
  logic [31:0] rd_addr;
  logic [31:0] wr_addr [16];
  logic [31:0] wr_data [16];
  bit          rd_pending = 0;
  int          rd_wait = 0, rd_lat = 0;
  bit          stall_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] link_val = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (req_valid && req_ready) acc_cyc = cyc;
    if (mem_valid && mem_ready) begin
      if (!mem_we) begin
        n_rd++;
        rd_addr      = mem_addr;
        rd_before_wr = n_wr;
        rd_pending   = 1;
        rd_wait      = rd_lat;
      end else begin
        if (n_wr < 16) begin
          wr_addr[n_wr] = mem_addr;
          wr_data[n_wr] = mem_wdata;
        end
        n_wr++;
        last_wr_cyc = cyc;
      end
    end
  end

  always @(negedge clk) begin
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready <= stall_on ? (lfsr[0] | lfsr[5]) : 1'b1;
    mem_rvalid <= 1'b0;
    if (rd_pending) begin
      if (rd_wait == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= link_val;
        rd_pending = 0;
      end else begin
        rd_wait--;
      end
    end
  end

  function automatic logic [31:0] exp_base(input logic [31:0] h);
    return {h[19:16], 6'b0, h[15:0], 6'b0};
  endfunction

  task automatic run_save(input logic [31:0] pcxi, input logic [31:0] head,
                          input logic [31:0] limit, input logic [7:0] ccpn,
                          input logic ie, input logic [31:0] link,
                          input logic [31:0] ctx_base, input bit stall, input int lat);
    logic [31:0] base, exp_pcxi, exp_head, exp_w;
    bit busy_ok = 1, seen = 0, addr_ok = 1, data_ok = 1;
    int done_cyc = -1;
    n_rd = 0; n_wr = 0; rd_before_wr = -1;
    stall_on = stall; rd_lat = lat; link_val = link;
    @(negedge clk);
    req_pcxi = pcxi; req_head = head; req_limit = limit;
    req_ccpn = ccpn; req_ie = ie;
    for (int j = 0; j < 15; j++) req_ctx[j*32 +: 32] = ctx_base + 32'(j + 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done) begin seen = 1; done_cyc = cyc; end
      else begin
        if (req_ready) busy_ok = 0;
        @(negedge clk);
      end
    end
    base     = exp_base(head);
    exp_pcxi = {ccpn, ie, 1'b1, pcxi[21:20], head[19:0]};
    exp_head = {head[31:20], link[19:0]};
    chk(seen, "R8 done seen", 32'(seen), 32'd1);
    chk(busy_ok, "R1 ready low while busy", 32'(busy_ok), 32'd1);
    chk(n_rd == 1 && rd_before_wr == 0, "R4 single read before writes", 32'(n_rd), 32'd1);
    chk(rd_addr == base, "R3 read address", rd_addr, base);
    chk(n_wr == 16, "R5 write count", 32'(n_wr), 32'd16);
    for (int k = 0; k < 16; k++) begin
      exp_w = (k == 0) ? pcxi : ctx_base + 32'(k);
      if (wr_addr[k] != base + 32'(4*k)) begin
        addr_ok = 0;
        chk(0, "R3 write address", wr_addr[k], base + 32'(4*k));
      end
      if (wr_data[k] != exp_w) begin
        data_ok = 0;
        chk(0, "R5 write data order", wr_data[k], exp_w);
      end
    end
    chk(addr_ok, "R3 all write addresses", 32'(addr_ok), 32'd1);
    chk(data_ok, "R5 all write data", 32'(data_ok), 32'd1);
    chk(done_cyc == last_wr_cyc, "R8 done timing", 32'(done_cyc), 32'(last_wr_cyc));
    chk(pcxi_o == exp_pcxi, "R6 pcxi update", pcxi_o, exp_pcxi);
    chk(head_o == exp_head, "R7 head update", head_o, exp_head);
    chk(depleted == (head == limit), "R9 depletion flag", 32'(depleted), 32'(head == limit));
    chk(empty == 1'b0, "R2 no empty on valid list", 32'(empty), 32'd0);
    @(negedge clk);
    chk(done == 1'b0 && depleted == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
    chk(head_o == exp_head, "R8 outputs hold", head_o, exp_head);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'd1);
    chk(mem_valid == 1'b0, "R10 no memory request", 32'(mem_valid), 32'd0);
    chk(!done && !empty && !depleted, "R10 flags low", {29'd0, done, empty, depleted}, 32'd0);
    chk(pcxi_o == 0 && head_o == 0, "R10 outputs zero", pcxi_o | head_o, 32'd0);
  endtask

  task automatic t_basic();
    run_save(32'h0000_0000, 32'h0003_1234, 32'h0000_0001, 8'h5A, 1'b1,
             32'h0003_1240, 32'h1000_0000, 0, 0);
  endtask

  task automatic t_backpressure();
    run_save(32'h1234_5678, 32'h0003_1240, 32'h0000_0001, 8'h07, 1'b0,
             32'h0003_1300, 32'h2000_0000, 1, 3);
  endtask

  task automatic t_fields();
    // upper head bits and pcxi [21:20] must survive; link upper bits ignored
    run_save(32'hFF3F_FFFF, 32'hABC5_FFFF, 32'h0000_0000, 8'h81, 1'b0,
             32'hDEAD_7777, 32'h3000_0000, 1, 1);
  endtask

  task automatic t_deplete();
    run_save(32'h0000_00AA, 32'h000F_0010, 32'h000F_0010, 8'hC3, 1'b1,
             32'h0000_0000, 32'h4000_0000, 1, 2);
  endtask

  task automatic t_empty();
    logic [31:0] p0, h0;
    bit seen_done = 0;
    p0 = pcxi_o; h0 = head_o;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    req_head = 32'h0; req_pcxi = 32'hFFFF_FFFF; req_limit = 32'h0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(empty == 1'b1 && cyc == acc_cyc, "R2 empty pulse timing", 32'(empty), 32'd1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done) seen_done = 1;
    end
    chk(empty == 1'b0, "R2 empty single cycle", 32'(empty), 32'd0);
    chk(n_rd == 0 && n_wr == 0, "R2 no memory access", 32'(n_rd + n_wr), 32'd0);
    chk(!seen_done, "R2 no done", 32'(seen_done), 32'd0);
    chk(pcxi_o == p0 && head_o == h0, "R2 outputs unchanged", head_o, h0);
    chk(req_ready == 1'b1, "R1 ready after empty", 32'(req_ready), 32'd1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_backpressure();
        t_fields();
        t_deplete();
        t_empty();
        t_basic();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule